// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block drives the command and address part of an 8-bit NAND flash bus. A controller sets an operation code, a block, page and column address, and a set of option flags, then pulses `start` for one clock. The sequencer builds the byte string for that operation and clocks each byte onto `dq`. Command bytes go out with `cle` high and address bytes with `ale` high. Every byte gets its own write-enable strobe of fixed length. Some operations end with a fixed settling wait. When the operation is finished, the block pulses `done`.

The flags select the confirm byte and the number of address bytes. On the first half of a two-plane operation the confirm is left out. A flag combination that cannot be served raises `err` for one clock and puts nothing on the bus. Data transfer, ECC and ready/busy polling are left to other logic.

Top module: `nand_seq`

## Requirements
- R1: After reset and whenever idle: `ce_n`=1, `we_n`=1, `cle`=0, `ale`=0, `dq`=0, `busy`=0, `done`=0, `err`=0.
- R2: Op 0 (page read) sends command 00h, then two column bytes, then three row bytes, then confirm 30h. The row is {blk,page} zero-extended to 24 bits and sent low byte first. Column byte 1 is col[7:0]. Column byte 2 is col[COL_W-1:8], zero-extended.
- R3: On op 0 the confirm is 35h when `f_idm`=1. Otherwise it is 3Ah when `f_cpbk`=1. When `f_tp1`=1 no confirm is sent at all.
- R4: On op 0 with `f_otp`=1 the command is AFh instead of 00h, and row bytes 2 and 3 are sent as 00h.
- R5: Op 0 with `f_otp`=1 together with `f_tp1` or `f_idm` is illegal. So is op 6 or op 7. An illegal start makes `err` high for exactly the next clock and produces no bus cycle.
- R6: Op 1 (plane queue read) sends 00h, five address bytes, then 32h.
- R7: Op 2 (cache step) sends the single command 31h, or 3Fh when `f_last`=1. Op 3 (cache random) sends 00h, five address bytes, then 31h.
- R8: Op 4 (random output) sends 05h and two column bytes, or 06h and five address bytes when `f_tp1`=1. Either form then sends E0h and holds `ce_n` low for WHR_CLK idle clocks.
- R9: Op 5 (erase) sends 60h and three row bytes (page bits zero), then D0h. With `f_tp1`=1 the confirm is D1h if `f_onfi`=1 and absent otherwise. Every erase then waits RR_CLK clocks.
- R10: Each byte holds `we_n` low for WE_LOW clocks and then high for WE_HIGH clocks. `cle`, `ale` and `dq` stay constant across both phases. `ce_n` stays low for the whole operation.
- R11: `done` is high for one clock, the first idle clock after an operation ends. A `start` received while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-clock request pulse |
| op | input | 3 | Operation code |
| blk | input | BLK_W | Block address |
| page | input | PAGE_W | Page address |
| col | input | COL_W | Column address |
| f_tp1 | input | 1 | First half of a two-plane operation |
| f_idm | input | 1 | Internal data move |
| f_otp | input | 1 | OTP page access |
| f_cpbk | input | 1 | Copyback variant |
| f_onfi | input | 1 | ONFI confirm for two-plane erase |
| f_last | input | 1 | Last page of a cache read |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| dq | output | 8 | Bus byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| err | output | 1 | Illegal request pulse |

## Verification
A corrupted sequence index or phase counter changes the bus within one strobe period. It shows up as a wrong `dq` byte, a misplaced `cle`/`ale`, or a strobe that is too long or too short, on the first clock after the fault. A wrong byte count or a wrong wait count moves `done` by whole clocks, so the bench compares every output on every clock. An error path that leaked bus cycles would show `ce_n` low on the clock after `err`.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int COL_W   = 12,
  parameter int PAGE_W  = 6,
  parameter int BLK_W   = 12,
  parameter int WE_LOW  = 2,
  parameter int WE_HIGH = 2,
  parameter int WHR_CLK = 6,
  parameter int RR_CLK  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [BLK_W-1:0]  blk,
  input  logic [PAGE_W-1:0] page,
  input  logic [COL_W-1:0]  col,
  input  logic              f_tp1,
  input  logic              f_idm,
  input  logic              f_otp,
  input  logic              f_cpbk,
  input  logic              f_onfi,
  input  logic              f_last,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic [7:0]        dq,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int NSEQ = 7;
  localparam int PW   = $clog2((WE_LOW > WE_HIGH ? WE_LOW : WE_HIGH) + 1);
  localparam int WW   = $clog2((WHR_CLK > RR_CLK ? WHR_CLK : RR_CLK) + 1);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_WAIT} st_t;

  function automatic logic [9:0] cmd(input logic [7:0] b);
    return {2'b10, b};
  endfunction
  function automatic logic [9:0] adr(input logic [7:0] b);
    return {2'b01, b};
  endfunction

  st_t           st;
  logic [9:0]    seq   [NSEQ];
  logic [9:0]    n_seq [NSEQ];
  logic [2:0]    len, n_len, idx;
  logic [WW-1:0] wlen, n_wlen, wcnt;
  logic [PW-1:0] cnt;
  logic          hi, illegal;

  logic [23:0] rrow, erow;
  logic [7:0]  c1, c2;
  assign rrow = 24'({blk, page});
  assign erow = 24'({blk, {PAGE_W{1'b0}}});
  assign c1   = col[7:0];
  assign c2   = 8'(col >> 8);

  always_comb begin
    for (int i = 0; i < NSEQ; i++) n_seq[i] = '0;
    n_len   = '0;
    n_wlen  = '0;
    illegal = 1'b0;
    case (op)
      3'd0: begin
        illegal  = f_otp && (f_tp1 || f_idm);
        n_seq[0] = cmd(f_otp ? 8'hAF : 8'h00);
        n_seq[1] = adr(c1);
        n_seq[2] = adr(c2);
        n_seq[3] = adr(rrow[7:0]);
        n_seq[4] = adr(f_otp ? 8'h00 : rrow[15:8]);
        n_seq[5] = adr(f_otp ? 8'h00 : rrow[23:16]);
        n_seq[6] = cmd(f_idm ? 8'h35 : (f_cpbk ? 8'h3A : 8'h30));
        n_len    = f_tp1 ? 3'd6 : 3'd7;
      end
      3'd1, 3'd3: begin
        n_seq[0] = cmd(8'h00);
        n_seq[1] = adr(c1);
        n_seq[2] = adr(c2);
        n_seq[3] = adr(rrow[7:0]);
        n_seq[4] = adr(rrow[15:8]);
        n_seq[5] = adr(rrow[23:16]);
        n_seq[6] = cmd(op == 3'd1 ? 8'h32 : 8'h31);
        n_len    = 3'd7;
      end
      3'd2: begin
        n_seq[0] = cmd(f_last ? 8'h3F : 8'h31);
        n_len    = 3'd1;
      end
      3'd4: begin
        n_wlen = WW'(WHR_CLK);
        if (f_tp1) begin
          n_seq[0] = cmd(8'h06);
          n_seq[1] = adr(c1);
          n_seq[2] = adr(c2);
          n_seq[3] = adr(rrow[7:0]);
          n_seq[4] = adr(rrow[15:8]);
          n_seq[5] = adr(rrow[23:16]);
          n_seq[6] = cmd(8'hE0);
          n_len    = 3'd7;
        end else begin
          n_seq[0] = cmd(8'h05);
          n_seq[1] = adr(c1);
          n_seq[2] = adr(c2);
          n_seq[3] = cmd(8'hE0);
          n_len    = 3'd4;
        end
      end
      3'd5: begin
        n_wlen   = WW'(RR_CLK);
        n_seq[0] = cmd(8'h60);
        n_seq[1] = adr(erow[7:0]);
        n_seq[2] = adr(erow[15:8]);
        n_seq[3] = adr(erow[23:16]);
        n_seq[4] = cmd((f_tp1 && f_onfi) ? 8'hD1 : 8'hD0);
        n_len    = (f_tp1 && !f_onfi) ? 3'd4 : 3'd5;
      end
      default: illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      len  <= '0;
      wlen <= '0;
      idx  <= '0;
      cnt  <= '0;
      hi   <= 1'b0;
      wcnt <= '0;
      done <= 1'b0;
      err  <= 1'b0;
      for (int i = 0; i < NSEQ; i++) seq[i] <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (illegal) err <= 1'b1;
          else begin
            for (int i = 0; i < NSEQ; i++) seq[i] <= n_seq[i];
            len  <= n_len;
            wlen <= n_wlen;
            idx  <= '0;
            cnt  <= '0;
            hi   <= 1'b0;
            st   <= S_BUS;
          end
        end
        S_BUS: if (!hi) begin
          if (cnt == PW'(WE_LOW - 1)) begin hi <= 1'b1; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end else if (cnt == PW'(WE_HIGH - 1)) begin
          hi  <= 1'b0;
          cnt <= '0;
          if (idx == len - 3'd1) begin
            wcnt <= '0;
            if (wlen != '0) st <= S_WAIT;
            else begin st <= S_IDLE; done <= 1'b1; end
          end else idx <= idx + 3'd1;
        end else cnt <= cnt + 1'b1;
        S_WAIT: if (wcnt == wlen - 1'b1) begin st <= S_IDLE; done <= 1'b1; end
                else wcnt <= wcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign ce_n = !busy;
  assign we_n = !(st == S_BUS && !hi);
  assign cle  = (st == S_BUS) && seq[idx][9];
  assign ale  = (st == S_BUS) && seq[idx][8];
  assign dq   = (st == S_BUS) ? seq[idx][7:0] : 8'h00;
endmodule

module nand_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic [7:0] dq,
  input logic       busy,
  input logic       done,
  input logic       err
);
  assert_strobe_in_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  assert_latch_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  assert_dq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(dq) && $stable(cle) && $stable(ale)));
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ce_n && !busy));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (we_n && !cle && !ale));
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
  .dq(dq), .busy(busy), .done(done), .err(err)
);

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  localparam int COL_W = 12, PAGE_W = 6, BLK_W = 12;
  localparam int WE_LOW = 2, WE_HIGH = 2, WHR_CLK = 6, RR_CLK = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [BLK_W-1:0] blk = 0;
  logic [PAGE_W-1:0] page = 0;
  logic [COL_W-1:0] col = 0;
  logic f_tp1 = 0, f_idm = 0, f_otp = 0, f_cpbk = 0, f_onfi = 0, f_last = 0;
  logic ce_n, cle, ale, we_n, busy, done, err;
  logic [7:0] dq;

  int n_vec = 0, n_bad = 0;
  logic [14:0] exp_q[$];
  string req_q[$];
  string cur_req = "R1";

  always #4 clk = ~clk;

  nand_seq #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W), .WE_LOW(WE_LOW),
             .WE_HIGH(WE_HIGH), .WHR_CLK(WHR_CLK), .RR_CLK(RR_CLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .blk(blk), .page(page),
    .col(col), .f_tp1(f_tp1), .f_idm(f_idm), .f_otp(f_otp), .f_cpbk(f_cpbk),
    .f_onfi(f_onfi), .f_last(f_last), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .dq(dq), .busy(busy), .done(done), .err(err));

  // packed {err,done,busy,ce_n,cle,ale,we_n,dq}
  localparam logic [14:0] IDLE_V = {3'b000, 1'b1, 2'b00, 1'b1, 8'h00};

  function automatic logic [14:0] actual();
    return {err, done, busy, ce_n, cle, ale, we_n, dq};
  endfunction

  task automatic check(input logic [14:0] e, input string r);
    logic [14:0] a;
    a = actual();
    n_vec++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", r, $time, a, e);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      if (exp_q.size() > 0) check(exp_q.pop_front(), req_q.pop_front());
      else check(IDLE_V, "R1");
    end
  end

  task automatic push_byte(input bit is_cmd, input logic [7:0] b);
    for (int k = 0; k < WE_LOW; k++) begin
      exp_q.push_back({3'b001, 1'b0, is_cmd, !is_cmd, 1'b0, b});
      req_q.push_back(cur_req);
    end
    for (int k = 0; k < WE_HIGH; k++) begin
      exp_q.push_back({3'b001, 1'b0, is_cmd, !is_cmd, 1'b1, b});
      req_q.push_back(cur_req);
    end
  endtask

  task automatic push_end(input int w);
    for (int k = 0; k < w; k++) begin
      exp_q.push_back({3'b001, 1'b0, 2'b00, 1'b1, 8'h00});
      req_q.push_back(cur_req);
    end
    exp_q.push_back({3'b010, 1'b1, 2'b00, 1'b1, 8'h00});
    req_q.push_back("R11");
  endtask

  task automatic model();
    logic [23:0] r;
    logic [7:0] a[5];
    r = 24'({blk, page});
    a[0] = col[7:0]; a[1] = 8'(col >> 8);
    a[2] = r[7:0]; a[3] = r[15:8]; a[4] = r[23:16];
    if (op > 5 || (op == 0 && f_otp && (f_tp1 || f_idm))) begin
      exp_q.push_back({3'b100, 1'b1, 2'b00, 1'b1, 8'h00});
      req_q.push_back("R5");
      return;
    end
    case (op)
      0: begin
        push_byte(1, f_otp ? 8'hAF : 8'h00);
        for (int i = 0; i < 5; i++) push_byte(0, (f_otp && i > 2) ? 8'h00 : a[i]);
        if (!f_tp1) push_byte(1, f_idm ? 8'h35 : f_cpbk ? 8'h3A : 8'h30);
        push_end(0);
      end
      1, 3: begin
        push_byte(1, 8'h00);
        for (int i = 0; i < 5; i++) push_byte(0, a[i]);
        push_byte(1, op == 1 ? 8'h32 : 8'h31);
        push_end(0);
      end
      2: begin push_byte(1, f_last ? 8'h3F : 8'h31); push_end(0); end
      4: begin
        push_byte(1, f_tp1 ? 8'h06 : 8'h05);
        for (int i = 0; i < (f_tp1 ? 5 : 2); i++) push_byte(0, a[i]);
        push_byte(1, 8'hE0);
        push_end(WHR_CLK);
      end
      default: begin
        r = 24'({blk, {PAGE_W{1'b0}}});
        push_byte(1, 8'h60);
        push_byte(0, r[7:0]); push_byte(0, r[15:8]); push_byte(0, r[23:16]);
        if (!f_tp1) push_byte(1, 8'hD0);
        else if (f_onfi) push_byte(1, 8'hD1);
        push_end(RR_CLK);
      end
    endcase
  endtask

  task automatic run(input string rq, input logic [2:0] o, input logic [BLK_W-1:0] b,
                     input logic [PAGE_W-1:0] p, input logic [COL_W-1:0] c,
                     input logic [5:0] fl);
    @(negedge clk);
    cur_req = rq;
    op = o; blk = b; page = p; col = c;
    {f_tp1, f_idm, f_otp, f_cpbk, f_onfi, f_last} = fl;
    start = 1;
    model();
    @(negedge clk);
    start = 0;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #20;
    n_vec++;
    if (actual() !== IDLE_V) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h expected=%h", actual(), IDLE_V);
    end
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    // flags: {tp1, idm, otp, cpbk, onfi, last}
    run("R2", 0, 12'hA5C, 6'h2B, 12'h9F3, 6'b000000);
    run("R2", 0, 12'hFFF, 6'h3F, 12'h0FF, 6'b000000);
    run("R3", 0, 12'h123, 6'h11, 12'h456, 6'b010000);
    run("R3", 0, 12'h123, 6'h11, 12'h456, 6'b000100);
    run("R3", 0, 12'h123, 6'h11, 12'h456, 6'b010100);
    run("R3", 0, 12'h321, 6'h05, 12'h7A0, 6'b100000);
    run("R4", 0, 12'hBEE, 6'h1D, 12'h812, 6'b001000);
    run("R5", 0, 12'hBEE, 6'h1D, 12'h812, 6'b101000);
    run("R5", 0, 12'hBEE, 6'h1D, 12'h812, 6'b011000);
    run("R5", 6, 12'h001, 6'h01, 12'h001, 6'b000000);
    run("R5", 7, 12'h001, 6'h01, 12'h001, 6'b000000);
    run("R6", 1, 12'h5A5, 6'h2A, 12'h3C3, 6'b000000);
    run("R7", 2, 12'h000, 6'h00, 12'h000, 6'b000000);
    run("R7", 2, 12'h000, 6'h00, 12'h000, 6'b000001);
    run("R7", 3, 12'h7E1, 6'h33, 12'hE07, 6'b000000);
    run("R8", 4, 12'h444, 6'h22, 12'hABC, 6'b000000);
    run("R8", 4, 12'h444, 6'h22, 12'hABC, 6'b100000);
    run("R9", 5, 12'hC37, 6'h3F, 12'h000, 6'b000000);
    run("R9", 5, 12'hC37, 6'h3F, 12'h000, 6'b100010);
    run("R9", 5, 12'hC37, 6'h3F, 12'h000, 6'b100000);
    run("R9", 5, 12'hC37, 6'h3F, 12'h000, 6'b000010);
    // R11: a start during an operation must be ignored
    @(negedge clk);
    cur_req = "R11";
    op = 2; f_last = 0; {f_tp1, f_idm, f_otp, f_cpbk, f_onfi} = 0;
    start = 1; model();
    @(negedge clk); start = 0;
    @(negedge clk); op = 5; start = 1;
    @(negedge clk); start = 0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule